// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block steers a multithreaded instruction front end that issues from one thread at a time. The active thread keeps issuing until it reports a long-latency event, such as a cache miss or a conditional branch that has not resolved. The controller then moves to another thread that can run. Each move costs a fixed number of dead cycles, set by the parameter `TAU`. No instruction issues during those cycles.

Events also carry an expected stall length. A stall no longer than `TAU` is not worth a switch, so the controller simply holds issue on the current thread for that many cycles. A thread that triggered a switch is parked as waiting. It stays parked until its completion input fires. The next thread is picked round-robin, starting just after the current one.

Top module: `thread_switch_ctrl`

## Requirements
- R1: After reset the active thread ID is 0 and the switching flag is low. Issue-valid follows the ready flag of thread 0.
- R2: Outside a switch or a short-stall wait, issue-valid is high exactly when the active thread's ready input is high and that thread is not parked.
- R3: An event accepted with stall length greater than `TAU`, when another thread is eligible, starts a switch. The switching flag is high for exactly `TAU` consecutive cycles, starting the cycle after the event. Issue-valid is low during those cycles.
- R4: The active thread ID takes the new thread's value in the last switching cycle. It stays unchanged in every cycle where the switching flag is low. Issue then resumes on the new thread.
- R5: The new thread is the first eligible thread (ready and not parked) found by searching from the current ID plus one, wrapping from `NUM_THREADS-1` to 0. The current thread is never chosen.
- R6: An event with stall length from 1 to `TAU` causes no switch. Issue-valid drops for exactly that many cycles and the ID is unchanged. A stall length of 0 has no effect.
- R7: A thread that raises a long event is parked. Bit t of the completion input un-parks thread t from the next cycle on.
- R8: If a long event finds no other eligible thread, the controller stays on the current thread. The switching flag stays low, and issue-valid stays low until that thread's completion arrives.
- R9: An event presented while issue-valid is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready_i | input | NUM_THREADS | Per-thread ready flags |
| evt_valid_i | input | 1 | Long-latency event from the active thread |
| evt_stall_i | input | STALL_W | Expected stall length of the event, in cycles |
| done_i | input | NUM_THREADS | Per-thread completion; bit t un-parks thread t |
| active_id_o | output | $clog2(NUM_THREADS) | Currently selected thread |
| issue_vld_o | output | 1 | An instruction may issue from the active thread this cycle |
| switching_o | output | 1 | A thread switch is in progress |

## Verification
Issue-valid and the ready check are combinational, so a ready change is visible within the same cycle. An event is sampled at a clock edge. The first switching or stalled cycle is the one right after that edge. The new ID appears `TAU` cycles after the edge, and issue resumes at `TAU+1`. A completion takes effect in the cycle after its edge. The bench drives inputs just after an edge and checks the outputs a short delay after the following edge. It steps one cycle per check, so each expected value refers to a known edge count from the stimulus.

// File: rtl/tswc_pkg.sv
// Shared types for the thread switch controller.
package tswc_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SWITCH = 2'd2
    } tswc_state_e;
endpackage

// File: rtl/tswc_park.sv
// Parked-thread tracker: one bit per thread, set on a long event,
// cleared by that thread's completion. Set wins over clear in one cycle.
module tswc_park #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] set_i,
    input  logic [NT-1:0] clr_i,
    output logic [NT-1:0] park_o
);
    logic [NT-1:0] park_q;

    // update parked bits
    always_ff @(posedge clk) begin
        if (!rst_n) park_q <= '0;
        else        park_q <= (park_q & ~clr_i) | set_i;
    end

    assign park_o = park_q;

    for (genvar t = 0; t < NT; t++) begin : g_chk
        assert_done_unparks_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[t] && !set_i[t]) |=> !park_o[t]);
    end
endmodule

// File: rtl/tswc_rr_pick.sv
// Round-robin picker: first eligible thread after cur_i, wrapping,
// never returning cur_i itself. Purely combinational; clock only for checks.
module tswc_rr_pick #(
    parameter int NT  = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IDW-1:0] cur_i,
    input  logic [NT-1:0]  elig_i,
    output logic           found_o,
    output logic [IDW-1:0] pick_o
);
    // search from farthest offset down so the nearest one wins
    always_comb begin
        found_o = 1'b0;
        pick_o  = cur_i;
        for (int i = NT - 1; i >= 1; i--) begin
            int j;
            j = (int'(cur_i) + i) % NT;
            if (elig_i[j]) begin
                found_o = 1'b1;
                pick_o  = IDW'(j);
            end
        end
    end

    assert_pick_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (elig_i[pick_o] && pick_o != cur_i));
endmodule

// File: rtl/tswc_seq.sv
// Switch sequencer: run / short-stall wait / switch states with a
// shared down-counter. Assumes TAU >= 1 and that evt_i is only
// meaningful while issue_o is high.
module tswc_seq
    import tswc_pkg::*;
#(
    parameter int NT  = 4,
    parameter int TAU = 3,
    parameter int SW  = 8,
    parameter int IDW = 2,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_i,
    input  logic [SW-1:0]  stall_i,
    input  logic           cur_elig_i,
    input  logic           found_i,
    input  logic [IDW-1:0] pick_i,
    output logic [IDW-1:0] cur_o,
    output logic [NT-1:0]  park_set_o,
    output logic [IDW-1:0] active_id_o,
    output logic           issue_o,
    output logic           switching_o
);
    tswc_state_e    state_q;
    logic [CW-1:0]  cnt_q;
    logic [IDW-1:0] cur_q, tgt_q;
    logic           take, long_evt, short_evt;

    // event classification, accepted only while issuing
    assign issue_o   = (state_q == ST_RUN) && cur_elig_i;
    assign take      = evt_i && issue_o;
    assign long_evt  = take && (int'(stall_i) > TAU);
    assign short_evt = take && (stall_i != '0) && (int'(stall_i) <= TAU);

    assign park_set_o  = long_evt ? (NT'(1) << cur_q) : '0;
    assign switching_o = (state_q == ST_SWITCH);
    assign active_id_o = (switching_o && cnt_q == CW'(1)) ? tgt_q : cur_q;
    assign cur_o       = cur_q;

    // state, counter and thread registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            cur_q   <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (long_evt && found_i) begin
                        state_q <= ST_SWITCH;
                        cnt_q   <= CW'(TAU);
                        tgt_q   <= pick_i;
                    end else if (short_evt) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= CW'(stall_i);
                    end
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) state_q <= ST_RUN;
                end
                ST_SWITCH: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        state_q <= ST_RUN;
                        cur_q   <= tgt_q;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // checker: length of the current run of switching cycles
    logic [CW:0] sw_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           sw_run_q <= '0;
        else if (switching_o) sw_run_q <= sw_run_q + 1'b1;
        else                  sw_run_q <= '0;
    end

    assert_switch_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        switching_o |-> (int'(sw_run_q) < TAU));
    assert_switch_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(switching_o) |-> (int'(sw_run_q) == TAU));
endmodule

// File: rtl/thread_switch_ctrl.sv
// Coarse-grained thread switch controller top. Combines the parked
// tracker, the round-robin picker and the sequencer. Assumes
// NUM_THREADS >= 2 and TAU >= 1; TAU must fit in STALL_W bits.
module thread_switch_ctrl
    import tswc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TAU         = 3,
    parameter int STALL_W     = 8,
    localparam int IDW        = $clog2(NUM_THREADS),
    localparam int CW         = $clog2(TAU + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_ready_i,
    input  logic                   evt_valid_i,
    input  logic [STALL_W-1:0]     evt_stall_i,
    input  logic [NUM_THREADS-1:0] done_i,
    output logic [IDW-1:0]         active_id_o,
    output logic                   issue_vld_o,
    output logic                   switching_o
);
    logic [NUM_THREADS-1:0] park, park_set, elig;
    logic [IDW-1:0]         cur, pick;
    logic                   found;

    // a thread may run when ready and not parked
    assign elig = thr_ready_i & ~park;

    tswc_park #(.NT(NUM_THREADS)) u_park (
        .clk(clk), .rst_n(rst_n), .set_i(park_set), .clr_i(done_i), .park_o(park)
    );

    tswc_rr_pick #(.NT(NUM_THREADS), .IDW(IDW)) u_pick (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .elig_i(elig),
        .found_o(found), .pick_o(pick)
    );

    tswc_seq #(.NT(NUM_THREADS), .TAU(TAU), .SW(STALL_W), .IDW(IDW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_valid_i), .stall_i(evt_stall_i),
        .cur_elig_i(elig[cur]), .found_i(found), .pick_i(pick),
        .cur_o(cur), .park_set_o(park_set), .active_id_o(active_id_o),
        .issue_o(issue_vld_o), .switching_o(switching_o)
    );

    assert_no_issue_in_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_vld_o && switching_o));
    assert_id_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !switching_o |-> $stable(active_id_o));
endmodule

// File: tb/thread_switch_ctrl_bench.sv
module thread_switch_ctrl_bench;
    localparam int NT  = 4;
    localparam int TAU = 3;
    localparam int SW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] rdy = '1;
    logic          evt = 1'b0;
    logic [SW-1:0] stall = '0;
    logic [NT-1:0] done = '0;
    logic [1:0]    id;
    logic          iv, sw;
    int            n_chk = 0, n_fail = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    thread_switch_ctrl #(.NUM_THREADS(NT), .TAU(TAU), .STALL_W(SW)) u_thread_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .thr_ready_i(rdy), .evt_valid_i(evt),
        .evt_stall_i(stall), .done_i(done), .active_id_o(id),
        .issue_vld_o(iv), .switching_o(sw)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, int e_id, bit e_sw, bit e_iv);
        n_chk++;
        if (int'(id) != e_id || sw !== e_sw || iv !== e_iv) begin
            n_fail++;
            $display("FAIL %s: id=%0d sw=%0b iv=%0b expected id=%0d sw=%0b iv=%0b",
                     tag, id, sw, iv, e_id, e_sw, e_iv);
        end
    endtask

    // present one event for one edge, then withdraw it
    task automatic event_pulse(int len);
        evt = 1'b1; stall = SW'(len);
        step();
        evt = 1'b0; stall = '0;
    endtask

    task automatic done_pulse(int t);
        done = NT'(1) << t;
        step();
        done = '0;
    endtask

    // a full switch from a to b: TAU switching cycles, then issue
    task automatic expect_switch(string tag, int a, int b);
        for (int k = 1; k <= TAU; k++) begin
            chk(tag, (k == TAU) ? b : a, 1'b1, 1'b0);
            step();
        end
        chk(tag, b, 1'b0, 1'b1);
    endtask

    initial begin
        step(); step(); step();
        chk("R1", 0, 1'b0, 1'b1);          // in reset
        rst_n = 1'b1;
        step();
        chk("R1", 0, 1'b0, 1'b1);

        rdy[0] = 1'b0; #1;
        chk("R2", 0, 1'b0, 1'b0);
        rdy[0] = 1'b1; #1;
        chk("R2", 0, 1'b0, 1'b1);

        // smallest long stall: TAU+1, thread 0 -> 1
        event_pulse(TAU + 1);
        expect_switch("R3", 0, 1);

        // thread 2 not ready: 1 -> 3 skipping it
        rdy[2] = 1'b0;
        event_pulse(200);
        expect_switch("R5", 1, 3);

        // 0,1 parked, 2 not ready: nowhere to go
        event_pulse(200);
        chk("R8", 3, 1'b0, 1'b0);
        step();
        chk("R8", 3, 1'b0, 1'b0);

        // event while not issuing is ignored
        event_pulse(200);
        chk("R9", 3, 1'b0, 1'b0);
        step();
        chk("R9", 3, 1'b0, 1'b0);

        done_pulse(3);
        chk("R7", 3, 1'b0, 1'b1);

        // un-park 1 only; wrap 3 -> 0 (parked) -> 1
        done_pulse(1);
        event_pulse(50);
        expect_switch("R4", 3, 1);

        // short stall of exactly TAU on thread 1
        rdy = '1;
        event_pulse(TAU);
        for (int k = 0; k < TAU; k++) begin
            chk("R6", 1, 1'b0, 1'b0);
            step();
        end
        chk("R6", 1, 1'b0, 1'b1);

        event_pulse(1);
        chk("R6", 1, 1'b0, 1'b0);
        step();
        chk("R6", 1, 1'b0, 1'b1);

        event_pulse(0);
        chk("R6", 1, 1'b0, 1'b1);

        // thread 0 still parked, 3 parked: 1 -> 2
        event_pulse(TAU + 1);
        expect_switch("R5", 1, 2);

        // completion of 0 lets 2 -> 0 wrap (3 parked)
        done_pulse(0);
        event_pulse(9);
        expect_switch("R7", 2, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule